// File: doc/BRIEF.md
# Low-Side Switch Channel Diagnostic Controller

This block holds the digital control and diagnostic logic for one channel of a protected low-side power switch. It takes a control request, a global enable, a standby level and four comparator flags from the analog side: overload, overtemperature, open load while conducting, and open load while off (drain voltage below the open-load threshold). From these it drives the gate-enable of the power stage and a single diagnostic status line.

With no fault present, the status line follows the commanded switching state. A detected error inverts that level. Overload and overtemperature are latched only when they persist, and they switch the stage off. The latch is released only after the control request has stayed low for a suppression window, so the next rising request restarts the stage.

The status output rises at once and falls only after a hold window. Under a PWM control input this gives a steady diagnostic level instead of one pulse per period. After reset and after every wake from standby, the status line is masked low while the analog side settles. Every time constant is a parameter counted in clock cycles, and every input passes through a two-flop synchronizer.

Top module: `lss_chan_diag`

## Requirements
- R1: `gate_on` is high only while the synchronized standby, enable and control inputs are all high and no fault is latched. Inputs reach the logic through two synchronizer flops, so a port change acts on `gate_on` two clock edges later.
- R2: With no error present, the unmasked status equals the synchronized level of (enable AND control). A rise shows one edge after the synchronized command rises.
- R3: If overload or overtemperature is present for QUAL_CYC consecutive synchronized cycles while the stage is commanded on, the fault latch sets and `gate_on` drops in the same cycle.
- R4: An overload or overtemperature burst shorter than QUAL_CYC cycles leaves the latch clear, `gate_on` high and the status unchanged.
- R5: A latched fault clears only after the synchronized control input has been low for SUPP_CYC consecutive cycles. A shorter low pulse followed by a high request leaves the stage off.
- R6: While an error is present, the raw status is (enable AND control) XOR 1, which is the inverse of its normal level.
- R7: Open load in the on state counts as an error on every cycle in which `gate_on` is high and the on-state open-load flag is set.
- R8: Open load in the off state counts as an error only after its flag has been high for OLF_CYC consecutive cycles with the stage off and standby high.
- R9: `status_out` rises one edge after the raw status rises. It falls only after the raw status has been low for HOLD_CYC consecutive cycles.
- R10: `status_out` is low during reset, while standby is low, and for MASK_CYC cycles after reset release or after a synchronized standby rise.
- R11: Standby low clears the fault latch, the filters and the status hold, and keeps `gate_on` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_in | input | 1 | Channel switch request, active high |
| enable_in | input | 1 | Global enable, active high |
| standby_in | input | 1 | High = active, low = standby |
| ovl_in | input | 1 | Overload comparator flag, active high |
| otemp_in | input | 1 | Overtemperature flag, active high |
| olon_in | input | 1 | On-state open-load flag, active high |
| oloff_in | input | 1 | Off-state open-load flag (drain below threshold), active high |
| gate_on | output | 1 | Gate enable of the power stage |
| status_out | output | 1 | Diagnostic status line |

## Verification
A change on any input port reaches `gate_on` two edges later, once it has crossed the synchronizer. The status line needs one more edge after that, for the hold register. The latch sets on the QUAL_CYC-th synchronized fault cycle and releases on the SUPP_CYC-th low control cycle. The bench keeps a per-cycle reference model that advances on the rising edge, applying those latencies. It compares both outputs with the model on every falling edge, so each result is checked in the exact cycle it falls due. Directed phases aim at the window edges, one cycle short and well past each count, and a seeded random phase mixes faults, PWM and standby.

// File: rtl/lss_pkg.sv
// Package: shared types for the low-side channel diagnostic block.
// Assumes all flags are active high after synchronization.
package lss_pkg;
    typedef struct packed {
        logic ctrl;
        logic en;
        logic stby;
        logic ovl;
        logic otemp;
        logic ol_on;
        logic ol_off;
    } lss_in_t;

    localparam int LSS_IN_W = $bits(lss_in_t);
endpackage

// File: rtl/lss_sync.sv
// Module: multi-bit flop-chain synchronizer, one chain per bit.
// Assumes bits are independent levels (no bus coherency needed), STAGES >= 2.
module lss_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    // shift asynchronous levels through the chain
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/lss_fault_latch.sv
// Module: qualifies overload/overtemperature and holds the shutdown latch.
// Sets after QUAL_CYC consecutive fault cycles while commanded on; releases
// after SUPP_CYC consecutive cycles of control low. clr (standby) wipes it.
module lss_fault_latch #(
    parameter int QUAL_CYC = 6,
    parameter int SUPP_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic demand,
    input  logic ctrl,
    input  logic fault,
    output logic latched
);
    localparam int QW = $clog2(QUAL_CYC + 1);
    localparam int SW = $clog2(SUPP_CYC + 1);

    logic [QW-1:0] qcnt;
    logic [SW-1:0] scnt;
    logic          arm;

    assign arm = demand && fault && !latched;

    // qualification and release counters plus the latch itself
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            latched <= 1'b0;
            qcnt    <= '0;
            scnt    <= '0;
        end else begin
            if (arm) begin
                if (qcnt == QW'(QUAL_CYC - 1)) begin
                    latched <= 1'b1;
                    qcnt    <= '0;
                end else begin
                    qcnt <= qcnt + QW'(1);
                end
            end else begin
                qcnt <= '0;
            end
            if (latched && !ctrl) begin
                if (scnt == SW'(SUPP_CYC - 1)) begin
                    latched <= 1'b0;
                    scnt    <= '0;
                end else begin
                    scnt <= scnt + SW'(1);
                end
            end else begin
                scnt <= '0;
            end
        end
    end

    // R3
    lat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latched) |-> $past(fault && demand));
    // R5
    lat_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(latched) && !$past(clr)) |-> $past(!ctrl));
endmodule

// File: rtl/lss_persist.sv
// Module: persistence filter; q rises once din has been high N edges in a row.
// Assumes N >= 1; any low cycle restarts the count.
module lss_persist #(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic q
);
    localparam int NW = $clog2(N + 1);

    logic [NW-1:0] cnt;

    // saturating run-length counter
    always_ff @(posedge clk) begin
        if (!rst_n || !din)  cnt <= '0;
        else if (cnt != NW'(N)) cnt <= cnt + NW'(1);
    end

    assign q = (cnt == NW'(N));

    // R8
    olf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q) |-> $past(din));
endmodule

// File: rtl/lss_status_hold.sv
// Module: status stretcher; rises at once, falls after HOLD_CYC low cycles.
// Assumes HOLD_CYC >= 1; clr forces the held status low.
module lss_status_hold #(
    parameter int HOLD_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic raw,
    output logic stat
);
    localparam int HW = $clog2(HOLD_CYC + 1);

    logic [HW-1:0] hcnt;

    // immediate set, delayed release
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            stat <= 1'b0;
            hcnt <= '0;
        end else if (raw) begin
            stat <= 1'b1;
            hcnt <= '0;
        end else if (stat) begin
            if (hcnt == HW'(HOLD_CYC - 1)) begin
                stat <= 1'b0;
                hcnt <= '0;
            end else begin
                hcnt <= hcnt + HW'(1);
            end
        end
    end

    // R9
    hold_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(stat) && !$past(clr)) |-> $past(!raw));
endmodule

// File: rtl/lss_chan_diag.sv
// Module: one channel of low-side switch control and diagnostics (top).
// Assumes asynchronous comparator levels at the ports; all timing in cycles.
module lss_chan_diag
    import lss_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_CYC    = 6,
    parameter int SUPP_CYC    = 10,
    parameter int OLF_CYC     = 8,
    parameter int HOLD_CYC    = 40,
    parameter int MASK_CYC    = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_in,
    input  logic enable_in,
    input  logic standby_in,
    input  logic ovl_in,
    input  logic otemp_in,
    input  logic olon_in,
    input  logic oloff_in,
    output logic gate_on,
    output logic status_out
);
    localparam int MW = $clog2(MASK_CYC + 1);

    lss_in_t        pins;
    lss_in_t        s;
    logic [LSS_IN_W-1:0] s_vec;
    logic           demand, latched, olf_din, olf_q, err, cmd, raw, stat;
    logic [MW-1:0]  mcnt;

    assign pins.ctrl   = ctrl_in;
    assign pins.en     = enable_in;
    assign pins.stby   = standby_in;
    assign pins.ovl    = ovl_in;
    assign pins.otemp  = otemp_in;
    assign pins.ol_on  = olon_in;
    assign pins.ol_off = oloff_in;

    lss_sync #(.W(LSS_IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pins), .q(s_vec)
    );
    assign s = lss_in_t'(s_vec);

    assign demand = s.stby && s.en && s.ctrl;

    lss_fault_latch #(.QUAL_CYC(QUAL_CYC), .SUPP_CYC(SUPP_CYC)) u_latch (
        .clk(clk), .rst_n(rst_n), .clr(!s.stby), .demand(demand),
        .ctrl(s.ctrl), .fault(s.ovl || s.otemp), .latched(latched)
    );

    assign gate_on = demand && !latched;

    assign olf_din = s.stby && s.ol_off && !gate_on;

    lss_persist #(.N(OLF_CYC)) u_olf (
        .clk(clk), .rst_n(rst_n), .din(olf_din), .q(olf_q)
    );

    assign err = latched || (gate_on && s.ol_on) || (!gate_on && olf_q);
    assign cmd = s.en && s.ctrl;
    assign raw = cmd ^ err;

    lss_status_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk(clk), .rst_n(rst_n), .clr(!s.stby), .raw(raw), .stat(stat)
    );

    // settle mask after reset release or standby wake
    always_ff @(posedge clk) begin
        if (!rst_n || !s.stby)       mcnt <= '0;
        else if (mcnt != MW'(MASK_CYC)) mcnt <= mcnt + MW'(1);
    end

    assign status_out = stat && s.stby && (mcnt == MW'(MASK_CYC));

    // R10
    mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s.stby) |-> !status_out);
    // R11
    stby_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s.stby |=> !latched);
endmodule

// File: tb/lss_chan_diag_tb.sv
// Bench: per-cycle reference model built from the requirements, directed
// phases at window edges plus seeded random stimulus.
module lss_chan_diag_tb_top;
    localparam int QUAL = 6, SUPP = 10, OLF = 8, HOLD = 40, MASK = 20;
    localparam int I_CTRL = 6, I_EN = 5, I_STB = 4, I_OVL = 3, I_OT = 2, I_OLN = 1, I_OLF = 0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [6:0] vin = '0;
    logic gate_on, status_out;
    int total = 0, bad = 0;
    string cur_req = "R10";

    always #5 clk = ~clk;

    lss_chan_diag dut_i (
        .clk(clk), .rst_n(rst_n),
        .ctrl_in(vin[I_CTRL]), .enable_in(vin[I_EN]), .standby_in(vin[I_STB]),
        .ovl_in(vin[I_OVL]), .otemp_in(vin[I_OT]), .olon_in(vin[I_OLN]),
        .oloff_in(vin[I_OLF]),
        .gate_on(gate_on), .status_out(status_out)
    );

    // reference model state
    logic [6:0] m1 = '0, m2 = '0;
    bit m_lat = 0, m_stat = 0;
    int m_qc = 0, m_sc = 0, m_fc = 0, m_hc = 0, m_mc = 0;

    function automatic bit exp_gate();
        return m2[I_STB] && m2[I_EN] && m2[I_CTRL] && !m_lat;
    endfunction

    function automatic bit exp_status();
        return m_stat && m2[I_STB] && (m_mc == MASK);
    endfunction

    // advance model one clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m1 = '0; m2 = '0; m_lat = 0; m_stat = 0;
            m_qc = 0; m_sc = 0; m_fc = 0; m_hc = 0; m_mc = 0;
        end else begin
            bit stb, dem, g, flt, olq, er, rw, nl;
            stb = m2[I_STB];
            dem = stb && m2[I_EN] && m2[I_CTRL];
            g   = dem && !m_lat;
            flt = m2[I_OVL] || m2[I_OT];
            olq = (m_fc == OLF);
            er  = m_lat || (g && m2[I_OLN]) || (!g && olq);
            rw  = (m2[I_EN] && m2[I_CTRL]) ^ er;
            if (!stb) begin
                m_lat = 0; m_qc = 0; m_sc = 0; m_stat = 0; m_hc = 0; m_mc = 0;
            end else begin
                nl = m_lat;
                if (dem && flt && !m_lat) begin
                    if (m_qc == QUAL - 1) begin nl = 1; m_qc = 0; end else m_qc++;
                end else m_qc = 0;
                if (m_lat && !m2[I_CTRL]) begin
                    if (m_sc == SUPP - 1) begin nl = 0; m_sc = 0; end else m_sc++;
                end else m_sc = 0;
                m_lat = nl;
                if (rw) begin m_stat = 1; m_hc = 0; end
                else if (m_stat) begin
                    if (m_hc == HOLD - 1) begin m_stat = 0; m_hc = 0; end else m_hc++;
                end
                if (m_mc != MASK) m_mc++;
            end
            if (!(stb && m2[I_OLF] && !g)) m_fc = 0;
            else if (m_fc != OLF) m_fc++;
            m2 = m1;
            m1 = vin;
        end
    end

    // compare outputs away from the active edge
    always @(negedge clk) begin
        total++;
        if (gate_on !== exp_gate()) begin
            bad++;
            $display("FAIL %s gate_on: actual=%0b expected=%0b t=%0t", cur_req, gate_on, exp_gate(), $time);
        end
        total++;
        if (status_out !== exp_status()) begin
            bad++;
            $display("FAIL %s status_out: actual=%0b expected=%0b t=%0t", cur_req, status_out, exp_status(), $time);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        cur_req = "R10 reset";
        cyc(5);
        rst_n = 1'b1;
        // R10: wake mask with stage commanded on
        cur_req = "R10 mask";
        vin[I_STB] = 1; vin[I_EN] = 1; vin[I_CTRL] = 1;
        cyc(30);
        // R1: control and enable combinations
        cur_req = "R1 gating";
        for (int i = 0; i < 40; i++) begin
            vin[I_CTRL] = i[0]; vin[I_EN] = (i % 7) != 3;
            cyc(3);
        end
        vin[I_EN] = 1; vin[I_CTRL] = 1; cyc(50);
        // R3: sustained overload latches
        cur_req = "R3 latch";
        vin[I_OVL] = 1; cyc(12); vin[I_OVL] = 0; cyc(20);
        // R5: short off pulse no restart, long off pulse restarts
        cur_req = "R5 release";
        vin[I_CTRL] = 0; cyc(SUPP - 2); vin[I_CTRL] = 1; cyc(15);
        vin[I_CTRL] = 0; cyc(SUPP + 5); vin[I_CTRL] = 1; cyc(60);
        // R4: bursts just under the qualification window
        cur_req = "R4 burst";
        for (int i = 0; i < 5; i++) begin
            vin[I_OT] = 1; cyc(QUAL - 1); vin[I_OT] = 0; cyc(10);
        end
        // R7: open load while on inverts status
        cur_req = "R7 ol on";
        vin[I_OLN] = 1; cyc(60); vin[I_OLN] = 0; cyc(10);
        // R8: off-state open load, short then long
        cur_req = "R8 ol off";
        vin[I_CTRL] = 0; cyc(HOLD + 10);
        for (int i = 0; i < 4; i++) begin
            vin[I_OLF] = 1; cyc(OLF - 2); vin[I_OLF] = 0; cyc(4);
        end
        vin[I_OLF] = 1; cyc(OLF + 20); vin[I_OLF] = 0; cyc(HOLD + 10);
        // R9: PWM gives a steady status level
        cur_req = "R9 pwm";
        for (int i = 0; i < 12; i++) begin
            vin[I_CTRL] = 1; cyc(6); vin[I_CTRL] = 0; cyc(6);
        end
        cyc(HOLD + 10);
        // R11: standby wipes a latched fault
        cur_req = "R11 standby";
        vin[I_CTRL] = 1; vin[I_OVL] = 1; cyc(QUAL + 8);
        vin[I_STB] = 0; cyc(10); vin[I_OVL] = 0; vin[I_STB] = 1; cyc(MASK + 20);
        // R2 R6: seeded random mix
        cur_req = "R2 R6 random";
        for (int i = 0; i < 3000; i++) begin
            if ($urandom % 8 == 0)   vin[I_CTRL] = ~vin[I_CTRL];
            if ($urandom % 97 == 0)  vin[I_EN]   = ~vin[I_EN];
            if ($urandom % 400 == 0) vin[I_STB]  = ~vin[I_STB];
            if (!vin[I_STB] && $urandom % 20 == 0) vin[I_STB] = 1;
            vin[I_OVL] = ($urandom % 30 == 0) ? ~vin[I_OVL] : vin[I_OVL];
            vin[I_OT]  = ($urandom % 60 == 0) ? ~vin[I_OT]  : vin[I_OT];
            vin[I_OLN] = ($urandom % 50 == 0) ? ~vin[I_OLN] : vin[I_OLN];
            vin[I_OLF] = ($urandom % 15 == 0) ? ~vin[I_OLF] : vin[I_OLF];
            cyc(1);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule